// File: doc/BRIEF.md
# Dual-Stream Event Splitter and Framer

This block sits between a digitizer and two output FIFOs. The digitizer sends 32-bit words with a data-enable. Three side flags mark special words: the main header, the first word of the second half of the event, and the digitizer trailer. The block cuts each event at the half mark. Words for channels 1–12 go to the upper FIFO, and words for channels 13–24 go to the lower FIFO. Each half becomes a self-contained frame:
- a locally built two-word header,
- a copy of the digitizer main header,
- the data,
- a one-word trailer holding a 16-bit running checksum of that half.

The digitizer trailer is absorbed and is never forwarded.

When an event starts, the block needs three clock cycles to insert the header words. During that window it raises busy toward the digitizer. It also raises busy whenever the FIFO currently being filled has 8 or fewer free words. A new header that arrives before the trailer of the previous event closes whatever halves are still open. The next local header then reports the truncation in its error field.

Top module: `event_split_framer`

## Requirements
- R1: An enabled word with no flag, seen between the end of header insertion and the half mark, is written unchanged to the upper FIFO one cycle after it is sampled.
- R2: The half-mark word and every later enabled unflagged word, up to the digitizer trailer, are written unchanged to the lower FIFO one cycle after sampling.
- R3: A header strobe sampled in cycle c makes both FIFOs receive the following words, while the inputs must carry no enabled word in c+1 to c+3:
  - in c+2, the word {0xFFAA in bits 31:16, error field in bits 15:0};
  - in c+4, the sampled main header word.
- R4: Both FIFOs receive in c+3 the local event number, zero-extended to 32 bits. The first event after reset is numbered 0, and each accepted header adds 1 (modulo 2^16).
- R5: A trailer word is {0xFF55 in bits 31:16, checksum in bits 15:0}. The upper trailer is written one cycle after the half mark. The lower trailer is written one cycle after the digitizer trailer strobe, and the digitizer trailer word itself is never written. A digitizer trailer seen before any half mark closes both halves in that cycle.
- R6: A half's checksum is the modulo-2^16 sum of bits 15:0 of every data word written to that half since the last header. It restarts at zero with each header.
- R7: A header arriving while a half is still open works as follows:
  - Each open half (both halves before the half mark, only the lower one after it) gets its trailer one cycle later.
  - The new event's error field is 0x0001.
  - After a properly closed event, the error field is 0x0000.
- R8: Outside header insertion, busy equals (free count of the target FIFO ≤ 8), within the same cycle. The target is the lower FIFO after the half mark, and the upper FIFO otherwise.
- R9: Busy is high in the three cycles after a header strobe is accepted. Each write strobe is high for exactly one cycle per written word and low otherwise. Enabled words arriving outside an event are dropped.
- R10: Under reset, both write strobes are low and the event counter returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Digitizer data clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Data-enable for the incoming word |
| inHdr | input | 1 | Marks the digitizer main header word |
| inHalf | input | 1 | Marks the first word of channels 13–24 |
| inTrl | input | 1 | Marks the digitizer trailer word |
| inData | input | 32 | Incoming word |
| upFree | input | 10 | Free words in the upper FIFO |
| loFree | input | 10 | Free words in the lower FIFO |
| busy | output | 1 | Stop request toward the digitizer |
| upWr | output | 1 | Upper FIFO write strobe |
| upData | output | 32 | Upper FIFO write word |
| loWr | output | 1 | Lower FIFO write strobe |
| loData | output | 32 | Lower FIFO write word |

## Verification
The results fall due at different times:
- Routed data words and every trailer appear on the FIFO side one cycle after the input word is sampled.
- The three inserted header words land two, three and four cycles after the header strobe.
- Busy follows the free-count inputs within the same cycle.

The bench keys each expected write by the cycle in which it must appear. On every falling edge it compares both strobes and both words, so a missing, early, late or extra write is caught. It checks busy one time step after driving the inputs of that cycle, so the combinational path is checked in the cycle it applies to.

// File: rtl/evsplit_pkg.sv
package evsplit_pkg;
  localparam logic [15:0] HDR_MARK = 16'hFFAA;
  localparam logic [15:0] TRL_MARK = 16'hFF55;

  typedef enum logic [2:0] {
    SEL_DATA, SEL_HEAD1, SEL_HEAD2, SEL_MAIN, SEL_TRAIL
  } wordSelT;

  typedef struct packed {
    logic    wrUp;
    wordSelT selUp;
    logic    addUp;
    logic    wrLo;
    wordSelT selLo;
    logic    addLo;
    logic    startEvt;
    logic    abortEvt;
  } ctrlStrobesT;
endpackage

// File: rtl/evsplit_ctrl.sv
module evsplit_ctrl
  import evsplit_pkg::*;
#(
  parameter int FREE_W   = 10,
  parameter int BUSY_THR = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inHdr,
  input  logic              inHalf,
  input  logic              inTrl,
  input  logic [FREE_W-1:0] upFree,
  input  logic [FREE_W-1:0] loFree,
  output ctrlStrobesT       ctl,
  output logic              busy
);
  localparam logic [FREE_W-1:0] THR = FREE_W'(BUSY_THR);

  typedef enum logic [1:0] {ST_IDLE, ST_INSERT, ST_UPPER, ST_LOWER} stateT;
  stateT state, stateNext;
  logic [1:0] insCnt;

  always_comb begin
    ctl = '0;
    stateNext = state;
    if (state == ST_INSERT) begin
      ctl.wrUp = 1'b1;
      ctl.wrLo = 1'b1;
      case (insCnt)
        2'd0:    begin ctl.selUp = SEL_HEAD1; ctl.selLo = SEL_HEAD1; end
        2'd1:    begin ctl.selUp = SEL_HEAD2; ctl.selLo = SEL_HEAD2; end
        default: begin ctl.selUp = SEL_MAIN;  ctl.selLo = SEL_MAIN;  end
      endcase
      if (insCnt == 2'd2) stateNext = ST_UPPER;
    end else if (inValid) begin
      if (inHdr) begin
        ctl.startEvt = 1'b1;
        stateNext = ST_INSERT;
        if (state == ST_UPPER) begin
          ctl.abortEvt = 1'b1;
          ctl.wrUp = 1'b1; ctl.selUp = SEL_TRAIL;
          ctl.wrLo = 1'b1; ctl.selLo = SEL_TRAIL;
        end else if (state == ST_LOWER) begin
          ctl.abortEvt = 1'b1;
          ctl.wrLo = 1'b1; ctl.selLo = SEL_TRAIL;
        end
      end else if (inTrl) begin
        if (state == ST_UPPER) begin
          ctl.wrUp = 1'b1; ctl.selUp = SEL_TRAIL;
        end
        if (state != ST_IDLE) begin
          ctl.wrLo = 1'b1; ctl.selLo = SEL_TRAIL;
        end
        stateNext = ST_IDLE;
      end else if (state == ST_UPPER) begin
        if (inHalf) begin
          ctl.wrUp = 1'b1; ctl.selUp = SEL_TRAIL;
          ctl.wrLo = 1'b1; ctl.addLo = 1'b1;
          stateNext = ST_LOWER;
        end else begin
          ctl.wrUp = 1'b1; ctl.addUp = 1'b1;
        end
      end else if (state == ST_LOWER) begin
        ctl.wrLo = 1'b1; ctl.addLo = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      insCnt <= '0;
    end else begin
      state  <= stateNext;
      insCnt <= (state == ST_INSERT) ? insCnt + 2'd1 : 2'd0;
    end
  end

  assign busy = (state == ST_INSERT) ||
                (((state == ST_LOWER) ? loFree : upFree) <= THR);

  AST_BUSY_LOW_SPACE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOWER && loFree <= THR) |-> busy); // R8
  AST_INSERT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    ctl.startEvt |=> (busy && state == ST_INSERT)); // R9
endmodule

// File: rtl/evsplit_lane.sv
module evsplit_lane
  import evsplit_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wr,
  input  wordSelT           sel,
  input  logic              add,
  input  logic              clr,
  input  logic [DATA_W-1:0] inData,
  input  logic [DATA_W-1:0] head1,
  input  logic [DATA_W-1:0] head2,
  input  logic [DATA_W-1:0] mainWord,
  output logic              wrOut,
  output logic [DATA_W-1:0] dataOut
);
  localparam int HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] sum;
  logic [DATA_W-1:0] word;

  always_comb begin
    case (sel)
      SEL_HEAD1: word = head1;
      SEL_HEAD2: word = head2;
      SEL_MAIN:  word = mainWord;
      SEL_TRAIL: word = {HALF_W'(TRL_MARK), sum};
      default:   word = inData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sum     <= '0;
      wrOut   <= 1'b0;
      dataOut <= '0;
    end else begin
      wrOut <= wr;
      if (wr) dataOut <= word;
      if (clr)      sum <= '0;
      else if (add) sum <= sum + inData[HALF_W-1:0];
    end
  end

  AST_SUM_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (sum == '0)); // R6
  AST_TRAIL_SUM: assert property (@(posedge clk) disable iff (!rstN)
    (wr && sel == SEL_TRAIL) |=> (wrOut && dataOut[HALF_W-1:0] == $past(sum))); // R5
endmodule

// File: rtl/evsplit_path.sv
module evsplit_path
  import evsplit_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EVT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       ctl,
  input  logic [DATA_W-1:0] inData,
  output logic              upWr,
  output logic [DATA_W-1:0] upData,
  output logic              loWr,
  output logic [DATA_W-1:0] loData
);
  localparam int HALF_W = DATA_W / 2;
  localparam int LANES  = 2;

  logic [DATA_W-1:0] mainReg;
  logic [EVT_W-1:0]  evtCnt, curEvt;
  logic              curErr;
  logic [DATA_W-1:0] head1, head2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainReg <= '0;
      evtCnt  <= '0;
      curEvt  <= '0;
      curErr  <= 1'b0;
    end else if (ctl.startEvt) begin
      mainReg <= inData;
      curEvt  <= evtCnt;
      evtCnt  <= evtCnt + 1'b1;
      curErr  <= ctl.abortEvt;
    end
  end

  assign head1 = {HALF_W'(HDR_MARK), HALF_W'(curErr)};
  assign head2 = DATA_W'(curEvt);

  logic [LANES-1:0]  laneWr, laneAdd, laneWrOut;
  wordSelT           laneSel  [LANES];
  logic [DATA_W-1:0] laneData [LANES];

  assign laneWr  = {ctl.wrLo, ctl.wrUp};
  assign laneAdd = {ctl.addLo, ctl.addUp};
  assign laneSel[0] = ctl.selUp;
  assign laneSel[1] = ctl.selLo;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    evsplit_lane #(.DATA_W(DATA_W)) uLane (
      .clk      (clk),
      .rstN     (rstN),
      .wr       (laneWr[g]),
      .sel      (laneSel[g]),
      .add      (laneAdd[g]),
      .clr      (ctl.startEvt),
      .inData   (inData),
      .head1    (head1),
      .head2    (head2),
      .mainWord (mainReg),
      .wrOut    (laneWrOut[g]),
      .dataOut  (laneData[g])
    );
  end

  assign upWr   = laneWrOut[0];
  assign upData = laneData[0];
  assign loWr   = laneWrOut[1];
  assign loData = laneData[1];

  AST_HEAD_MARK: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrUp && ctl.selUp == SEL_HEAD1) |=>
      (upWr && loWr && upData[DATA_W-1:HALF_W] == HALF_W'(HDR_MARK))); // R3
  AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ctl.startEvt |=> (curErr == $past(ctl.abortEvt))); // R7
endmodule

// File: rtl/event_split_framer.sv
module event_split_framer
  import evsplit_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int EVT_W    = 16,
  parameter int FREE_W   = 10,
  parameter int BUSY_THR = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inHdr,
  input  logic              inHalf,
  input  logic              inTrl,
  input  logic [DATA_W-1:0] inData,
  input  logic [FREE_W-1:0] upFree,
  input  logic [FREE_W-1:0] loFree,
  output logic              busy,
  output logic              upWr,
  output logic [DATA_W-1:0] upData,
  output logic              loWr,
  output logic [DATA_W-1:0] loData
);
  ctrlStrobesT ctl;

  evsplit_ctrl #(.FREE_W(FREE_W), .BUSY_THR(BUSY_THR)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inHdr   (inHdr),
    .inHalf  (inHalf),
    .inTrl   (inTrl),
    .upFree  (upFree),
    .loFree  (loFree),
    .ctl     (ctl),
    .busy    (busy)
  );

  evsplit_path #(.DATA_W(DATA_W), .EVT_W(EVT_W)) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .inData (inData),
    .upWr   (upWr),
    .upData (upData),
    .loWr   (loWr),
    .loData (loData)
  );
endmodule

// File: tb/tb_event_split_framer.sv
module tb_event_split_framer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inHdr = 1'b0, inHalf = 1'b0, inTrl = 1'b0;
  logic [31:0] inData = '0;
  logic [9:0]  upFree = 10'd100, loFree = 10'd100;
  logic        busy, upWr, loWr;
  logic [31:0] upData, loData;

  event_split_framer dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inHdr(inHdr), .inHalf(inHalf),
    .inTrl(inTrl), .inData(inData), .upFree(upFree), .loFree(loFree),
    .busy(busy), .upWr(upWr), .upData(upData), .loWr(loWr), .loData(loData)
  );

  always #5 clk = ~clk;

  int nCmp = 0, nBad = 0, cyc = 0;
  bit finished = 0;

  // reference model state
  logic [31:0] upSched [int];
  string       upTag   [int];
  logic [31:0] loSched [int];
  string       loTag   [int];
  int          mode = 0;      // 0 outside event, 1 upper half, 2 lower half
  int          insEnd = -1;
  logic [15:0] sumU = '0, sumL = '0, evtNo = '0;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic void putUp(int at, logic [31:0] w, string tag);
    upSched[at] = w; upTag[at] = tag;
  endfunction
  function automatic void putLo(int at, logic [31:0] w, string tag);
    loSched[at] = w; loTag[at] = tag;
  endfunction

  task automatic checkOutputs();
    if (upSched.exists(cyc)) begin
      check(upTag[cyc], "upper strobe", 32'(upWr), 32'd1);
      check(upTag[cyc], "upper word", upData, upSched[cyc]);
      upSched.delete(cyc);
    end else check("R9", "upper strobe idle", 32'(upWr), 32'd0);
    if (loSched.exists(cyc)) begin
      check(loTag[cyc], "lower strobe", 32'(loWr), 32'd1);
      check(loTag[cyc], "lower word", loData, loSched[cyc]);
      loSched.delete(cyc);
    end else check("R9", "lower strobe idle", 32'(loWr), 32'd0);
  endtask

  task automatic step(bit v, bit h, bit hf, bit t, logic [31:0] d);
    bit inIns;
    bit expBusy;
    bit err;
    int c;
    @(negedge clk);
    cyc++;
    c = cyc;
    checkOutputs();
    inValid = v; inHdr = h; inHalf = hf; inTrl = t; inData = d;
    #1;
    inIns = (c <= insEnd);
    expBusy = inIns || (((mode == 2) ? loFree : upFree) <= 10'd8);
    check(inIns ? "R9" : "R8", "busy", 32'(busy), 32'(expBusy));
    if (v && !inIns) begin
      if (h) begin
        err = (mode != 0);
        if (mode == 1) begin
          putUp(c + 1, {16'hFF55, sumU}, "R7");
          putLo(c + 1, {16'hFF55, sumL}, "R7");
        end else if (mode == 2) putLo(c + 1, {16'hFF55, sumL}, "R7");
        putUp(c + 2, {16'hFFAA, 15'd0, err}, err ? "R7" : "R3");
        putLo(c + 2, {16'hFFAA, 15'd0, err}, err ? "R7" : "R3");
        putUp(c + 3, {16'h0, evtNo}, "R4");
        putLo(c + 3, {16'h0, evtNo}, "R4");
        putUp(c + 4, d, "R3");
        putLo(c + 4, d, "R3");
        evtNo++;
        sumU = '0; sumL = '0;
        mode = 1;
        insEnd = c + 3;
      end else if (t) begin
        if (mode == 1) putUp(c + 1, {16'hFF55, sumU}, "R5 R6");
        if (mode != 0) putLo(c + 1, {16'hFF55, sumL}, "R5 R6");
        mode = 0;
      end else if (mode == 1 && hf) begin
        putUp(c + 1, {16'hFF55, sumU}, "R5 R6");
        putLo(c + 1, d, "R2");
        sumL += d[15:0];
        mode = 2;
      end else if (mode == 1) begin
        putUp(c + 1, d, "R1");
        sumU += d[15:0];
      end else if (mode == 2) begin
        putLo(c + 1, d, "R2");
        sumL += d[15:0];
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 32'h0);
  endtask

  task automatic header(logic [31:0] mh);
    step(1, 1, 0, 0, mh);
    idle(3);
  endtask

  task automatic sendEvent(int nUp, int nLo, bit closeIt);
    header($urandom());
    for (int i = 0; i < nUp; i++) step(1, 0, 0, 0, $urandom());
    for (int i = 0; i < nLo; i++) step(1, 0, (i == 0), 0, $urandom());
    if (closeIt) step(1, 0, 0, 1, 32'hDEAD_BEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "upper strobe in reset", 32'(upWr), 32'd0);
    check("R10", "lower strobe in reset", 32'(loWr), 32'd0);
    rstN = 1'b1;
    idle(2);

    // R1 R2 R3 R4 R5 R6: plain event, first number 0
    header(32'hA5A5_0001);
    step(1, 0, 0, 0, 32'h0000_0010);
    step(1, 0, 0, 0, 32'h1234_0020);
    idle(1);
    step(1, 0, 0, 0, 32'hFFFF_0030);
    step(1, 0, 1, 0, 32'h0000_0100);
    step(1, 0, 0, 0, 32'h0000_0200);
    step(1, 0, 0, 1, 32'hCAFE_F00D);
    idle(2);

    // R9: stray words outside an event are dropped
    step(1, 0, 0, 0, 32'h1111_1111);
    step(1, 0, 1, 0, 32'h2222_2222);
    step(1, 0, 0, 1, 32'h3333_3333);
    idle(2);

    // R6: checksum wraps modulo 2^16; header right after a trailer
    header(32'hB0B0_0002);
    step(1, 0, 0, 0, 32'h0000_FFFF);
    step(1, 0, 0, 0, 32'h0000_FFFF);
    step(1, 0, 0, 0, 32'h0000_0003);
    step(1, 0, 1, 0, 32'h0000_8000);
    step(1, 0, 0, 0, 32'h0000_8001);
    step(1, 0, 0, 1, 32'h0);
    header(32'hC0C0_0003);
    // R5: trailer with no half mark closes both halves
    step(1, 0, 0, 0, 32'h0000_0007);
    step(1, 0, 0, 1, 32'h0);
    idle(1);

    // R7: abort while in upper half, then while in lower half, then clean
    header(32'hD0D0_0004);
    step(1, 0, 0, 0, 32'h0000_0005);
    header(32'hD0D0_0005);
    step(1, 0, 0, 0, 32'h0000_0001);
    step(1, 0, 1, 0, 32'h0000_0009);
    header(32'hD0D0_0006);
    step(1, 0, 0, 1, 32'h0);
    sendEvent(1, 1, 1);
    idle(2);

    // R8: busy threshold on the target FIFO
    upFree = 10'd8; idle(1);
    upFree = 10'd9; idle(1);
    header(32'hE0E0_0007);
    loFree = 10'd8;
    step(1, 0, 0, 0, 32'h0000_0001);
    upFree = 10'd3;
    step(1, 0, 1, 0, 32'h0000_0002);
    upFree = 10'd100;
    idle(1);
    loFree = 10'd9; idle(1);
    loFree = 10'd100;
    step(1, 0, 0, 1, 32'h0);
    idle(2);

    // mixed traffic
    for (int e = 0; e < 200; e++) begin
      upFree = 10'($urandom_range(0, 20));
      loFree = 10'($urandom_range(0, 20));
      sendEvent($urandom_range(0, 6), $urandom_range(0, 6), ($urandom_range(0, 5) != 0));
      idle($urandom_range(0, 2));
    end
    idle(6);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nCmp++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule